// File: doc/BRIEF.md
# Sampled Shadow-Tag Miss Monitor

The block watches the last-level cache access stream of two applications that share one physical cache. For each application it predicts the misses that application would take if it ran by itself, on two cache sizes at once: a large configuration (16 ways, 4096 sets) and a small configuration (16 ways, 512 sets). Lines are 64 bytes, and the block receives line addresses, so both configurations take their set index from the low line-address bits.

Each application owns a private pair of tag-only directories, one per configuration, and the access's application ID picks the pair. No data is stored; a lookup yields only hit or miss. Only sets whose index is a multiple of 32 are modelled. Because 32 divides both set counts, one test on the low five line-address bits selects the sample for both sizes. Every other access is dropped. Each directory set uses true LRU with 4-bit ages. A hit promotes the way to most recent. A miss fills the least recent way and makes it most recent.

Per application and per configuration, a saturating access counter and a saturating miss counter feed a readout port. Software divides the misses by its own instruction counts to get misses per instruction for each thread on each cache size. A clear strobe zeroes all counters.

Top module: `shadow_miss_monitor`

## Requirements
- R1: After reset every counter reads zero and every shadow way is invalid.
- R2: An access whose line-address bits [4:0] are not all zero changes no counter and no shadow directory.
- R3: A sampled access (bits [4:0] zero) increments the access counter of its application for both the large and the small configuration.
- R4: A lookup that finds no valid way with a matching tag is a miss and increments the miss counter of that application and configuration, so the first touch after reset misses.
- R5: A sampled access whose tag is already held in its set hits and leaves the miss counter unchanged.
- R6: The directories of the two applications are independent: a tag filled by one application does not make the other application hit.
- R7: Large set index is line-address bits [11:0] with tag bits [25:12]. Small set index is bits [8:0] with tag bits [25:9]. Each set holds 16 tags, and a 17th distinct tag evicts the least recently used one, so the two sizes can disagree on one access.
- R8: A hit makes its way most recent, so it survives the next eviction in that set.
- R9: The clear strobe zeroes all counters, and an access in the same cycle is counted after the clear.
- R10: Counters saturate at their all-ones value and never wrap.
- R11: The readout returns counter number app*4 + cfg*2 + kind, where cfg is 0 for large and 1 for small, and kind is 0 for accesses and 1 for misses. The value reflects every access accepted up to the previous clock edge.
- R12: One access is accepted per cycle, and back-to-back accesses to one set see each other's updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access strobe |
| accApp | input | 1 | Application ID of the access |
| accLineAddr | input | 26 | Line address (byte address without the 6 offset bits) |
| clearCnt | input | 1 | Zero all counters |
| rdSel | input | 3 | Counter index for readout |
| rdData | output | CNT_W (32) | Selected counter value |

## Verification
Assertions check on every cycle that at most one way of a looked-up set matches the tag and that exactly one way holds the oldest age. This shows the LRU ages stay a permutation. They also check that no counter wraps, that miss counts never exceed access counts, that counters hold still when there is no sampled access and no clear, and that a lone clear leaves zeros. Only the bench scenarios show the actual hit and miss outcomes. These are LRU eviction order, hit promotion, the large-versus-small disagreement, isolation between the applications, and the order of a clear and an access in the same cycle. The bench compares these against a behavioural recency-list model every cycle.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int APPS  = 2;
  localparam int APP_W = 1;

  typedef struct packed {
    logic             lookup;
    logic             clear;
    logic [APP_W-1:0] app;
  } strobe_t;
endpackage

// File: rtl/ssm_ctrl.sv
module ssm_ctrl #(
  parameter int LINE_W      = 26,
  parameter int SAMPLE_BITS = 5
) (
  input  logic                  accValid,
  input  logic [ssm_pkg::APP_W-1:0] accApp,
  input  logic [LINE_W-1:0]     accLineAddr,
  input  logic                  clearCnt,
  output ssm_pkg::strobe_t      st
);
  logic sampled;

  // a set is in the sample when its index is a multiple of 2**SAMPLE_BITS
  assign sampled   = (accLineAddr[SAMPLE_BITS-1:0] == '0);
  assign st.lookup = accValid && sampled;
  assign st.clear  = clearCnt;
  assign st.app    = accApp;
endmodule

// File: rtl/ssm_shadow_dir.sv
module ssm_shadow_dir #(
  parameter int LINE_W      = 26,
  parameter int SET_BITS    = 12,
  parameter int WAYS        = 16,
  parameter int AGE_W       = 4,
  parameter int SAMPLE_BITS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssm_pkg::strobe_t  st,
  input  logic [LINE_W-1:0] lineAddr,
  output logic              missOut
);
  localparam int SLOT_BITS = SET_BITS - SAMPLE_BITS;
  localparam int SLOTS     = 1 << SLOT_BITS;
  localparam int TAG_W     = LINE_W - SET_BITS;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
    logic [AGE_W-1:0] age;
  } way_t;

  way_t [WAYS-1:0] dirMem [ssm_pkg::APPS][SLOTS];

  logic [SLOT_BITS-1:0] slot;
  logic [TAG_W-1:0]     tag;
  way_t [WAYS-1:0]      curSet, nxtSet;
  logic [WAYS-1:0]      hitVec, victimVec;
  logic                 hit;
  logic [AGE_W-1:0]     touchAge;

  assign slot   = lineAddr[SET_BITS-1:SAMPLE_BITS];
  assign tag    = lineAddr[LINE_W-1:SET_BITS];
  assign curSet = dirMem[st.app][slot];

  always_comb begin
    touchAge = AGE_W'(WAYS-1);
    for (int w = 0; w < WAYS; w++) begin
      hitVec[w]    = curSet[w].valid && (curSet[w].tag == tag);
      victimVec[w] = (curSet[w].age == AGE_W'(WAYS-1));
    end
    hit = |hitVec;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) touchAge = curSet[w].age;
    for (int w = 0; w < WAYS; w++) begin
      nxtSet[w] = curSet[w];
      if (hitVec[w] || (!hit && victimVec[w])) begin
        nxtSet[w].valid = 1'b1;
        nxtSet[w].tag   = tag;
        nxtSet[w].age   = '0;
      end else if (curSet[w].age < touchAge) begin
        nxtSet[w].age = curSet[w].age + 1'b1;
      end
    end
  end

  assign missOut = !hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < ssm_pkg::APPS; a++)
        for (int s = 0; s < SLOTS; s++)
          for (int w = 0; w < WAYS; w++)
            dirMem[a][s][w] <= '{valid: 1'b0, tag: '0, age: AGE_W'(w)};
    end else if (st.lookup) begin
      dirMem[st.app][slot] <= nxtSet;
    end
  end

  // R5: tags in one set stay unique, so at most one way matches
  a_r5_single_match: assert property (@(posedge clk) disable iff (!rstN)
    st.lookup |-> $onehot0(hitVec));
  // R7: ages remain a permutation, so exactly one way is least recent
  a_r7_single_victim: assert property (@(posedge clk) disable iff (!rstN)
    st.lookup |-> $onehot(victimVec));
endmodule

// File: rtl/ssm_counters.sv
module ssm_counters #(
  parameter int CNT_W = 32,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ssm_pkg::strobe_t st,
  input  logic             missLarge,
  input  logic             missSmall,
  input  logic [SEL_W-1:0] rdSel,
  output logic [CNT_W-1:0] rdData
);
  localparam int NCNT = ssm_pkg::APPS * 4;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt [NCNT];
  logic [CNT_W-1:0] nxt [NCNT];

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    localparam int APP  = i / 4;
    localparam int CFG  = (i / 2) % 2;
    localparam int KIND = i % 2;
    logic             inc;
    logic [CNT_W-1:0] base;

    always_comb begin
      inc  = st.lookup && (st.app == ssm_pkg::APP_W'(APP)) &&
             ((KIND == 0) || ((CFG == 0) ? missLarge : missSmall));
      base = st.clear ? '0 : cnt[i];
      nxt[i] = (inc && base != CMAX) ? base + 1'b1 : base;
    end

    always_ff @(posedge clk) begin
      if (!rstN) cnt[i] <= '0;
      else       cnt[i] <= nxt[i];
    end

    // R10: without a clear a counter never moves down (no wrap)
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
      !st.clear |=> cnt[i] >= $past(cnt[i]));
    // R2: no sampled access and no clear leaves every counter still
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
      (!st.lookup && !st.clear) |=> $stable(cnt[i]));
    // R9: a clear with no access leaves zero
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
      (st.clear && !st.lookup) |=> cnt[i] == '0);
    if (KIND == 1) begin : g_bound
      // R4: misses never exceed accesses of the same app and config
      a_r4_miss_bounded: assert property (@(posedge clk) disable iff (!rstN)
        cnt[i] <= cnt[i-1]);
    end
  end

  assign rdData = cnt[rdSel];
endmodule

// File: rtl/shadow_miss_monitor.sv
module shadow_miss_monitor #(
  parameter int LINE_W      = 26,
  parameter int LARGE_SETB  = 12,
  parameter int SMALL_SETB  = 9,
  parameter int WAYS        = 16,
  parameter int AGE_W       = 4,
  parameter int SAMPLE_BITS = 5,
  parameter int CNT_W       = 32,
  parameter int SEL_W       = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      accValid,
  input  logic [ssm_pkg::APP_W-1:0] accApp,
  input  logic [LINE_W-1:0]         accLineAddr,
  input  logic                      clearCnt,
  input  logic [SEL_W-1:0]          rdSel,
  output logic [CNT_W-1:0]          rdData
);
  ssm_pkg::strobe_t st;
  logic missLarge, missSmall;

  ssm_ctrl #(.LINE_W(LINE_W), .SAMPLE_BITS(SAMPLE_BITS)) u_ctrl (
    .accValid(accValid), .accApp(accApp), .accLineAddr(accLineAddr),
    .clearCnt(clearCnt), .st(st));

  ssm_shadow_dir #(.LINE_W(LINE_W), .SET_BITS(LARGE_SETB), .WAYS(WAYS),
                   .AGE_W(AGE_W), .SAMPLE_BITS(SAMPLE_BITS)) u_large (
    .clk(clk), .rstN(rstN), .st(st), .lineAddr(accLineAddr), .missOut(missLarge));

  ssm_shadow_dir #(.LINE_W(LINE_W), .SET_BITS(SMALL_SETB), .WAYS(WAYS),
                   .AGE_W(AGE_W), .SAMPLE_BITS(SAMPLE_BITS)) u_small (
    .clk(clk), .rstN(rstN), .st(st), .lineAddr(accLineAddr), .missOut(missSmall));

  ssm_counters #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rstN(rstN), .st(st), .missLarge(missLarge), .missSmall(missSmall),
    .rdSel(rdSel), .rdData(rdData));
endmodule

// File: tb/shadow_miss_monitor_test.sv
module shadow_miss_monitor_test;
  localparam int CW   = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          accValid = 1'b0;
  logic [0:0]    accApp = '0;
  logic [25:0]   accLineAddr = '0;
  logic          clearCnt = 1'b0;
  logic [2:0]    rdSel = '0;
  logic [CW-1:0] rdData;

  int checks = 0;
  int errors = 0;
  int selPtr = 0;
  int mcnt [8];
  int mtag [2][2][128][16];
  int mfill [2][2][128];

  always #5 clk = ~clk;

  shadow_miss_monitor #(.CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accApp(accApp),
    .accLineAddr(accLineAddr), .clearCnt(clearCnt), .rdSel(rdSel), .rdData(rdData));

  function automatic bit modelLookup(int ap, int cfg, int slot, int tag);
    int idx = -1;
    for (int k = 0; k < mfill[ap][cfg][slot]; k++)
      if (mtag[ap][cfg][slot][k] == tag) idx = k;
    modelLookup = (idx >= 0);
    if (idx < 0) begin
      if (mfill[ap][cfg][slot] < 16) mfill[ap][cfg][slot]++;
      idx = mfill[ap][cfg][slot] - 1;
    end
    for (int k = idx; k > 0; k--) mtag[ap][cfg][slot][k] = mtag[ap][cfg][slot][k-1];
    mtag[ap][cfg][slot][0] = tag;
  endfunction

  function automatic void bump(int i);
    if (mcnt[i] < CMAX) mcnt[i]++;
  endfunction

  function automatic void modelStep(bit v, int ap, int la, bit clr);
    bit h;
    if (clr) for (int i = 0; i < 8; i++) mcnt[i] = 0;
    if (v && (la % 32) == 0) begin
      h = modelLookup(ap, 0, (la >> 5) & 127, la >> 12);
      bump(ap*4);     if (!h) bump(ap*4 + 1);
      h = modelLookup(ap, 1, (la >> 5) & 15, la >> 9);
      bump(ap*4 + 2); if (!h) bump(ap*4 + 3);
    end
  endfunction

  task automatic step(bit v, int ap, int la, bit clr, string req);
    @(negedge clk);
    accValid = v; accApp = ap[0:0]; accLineAddr = la[25:0]; clearCnt = clr;
    rdSel = selPtr[2:0];
    @(posedge clk);
    modelStep(v, ap, la, clr);
    #2;
    checks++;
    if (int'(rdData) != mcnt[selPtr]) begin
      errors++;
      $display("FAIL %s (R11 sel %0d): got %0d expected %0d", req, selPtr, rdData, mcnt[selPtr]);
    end
    selPtr = (selPtr + 1) % 8;
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, req);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 2; a++)
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < 128; s++) mfill[a][c][s] = 0;
    for (int i = 0; i < 8; i++) mcnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    idle(8, "R1 reset");
    // R2: unsampled addresses are ignored
    step(1, 0, 'h3, 0, "R2"); step(1, 1, 'h21, 0, "R2"); step(1, 0, 'h1001, 0, "R2");
    idle(8, "R2 ignored");
    // R3 R4: first touches miss and count accesses
    step(1, 0, 'h1000, 0, "R4"); step(1, 0, 'h2040, 0, "R3");
    idle(8, "R3 R4");
    // R5 R12: back-to-back repeats hit
    step(1, 0, 'h1000, 0, "R5"); step(1, 0, 'h1000, 0, "R12"); step(1, 0, 'h2040, 0, "R5");
    idle(8, "R5");
    // R6: other app misses on same tags
    step(1, 1, 'h1000, 0, "R6"); step(1, 1, 'h1000, 0, "R6");
    idle(8, "R6");
    // R7: 17 distinct tags in small set 0 evict the first; large still holds it
    for (int k = 1; k <= 17; k++) step(1, 0, k << 9, 0, "R7");
    step(1, 0, 1 << 9, 0, "R7");
    idle(8, "R7");
    // R8: hit promotion protects a tag in small set 1
    step(1, 1, 'h20 | (100 << 9), 0, "R8");
    for (int k = 1; k <= 15; k++) step(1, 1, 'h20 | ((100 + k) << 9), 0, "R8");
    step(1, 1, 'h20 | (100 << 9), 0, "R8");
    step(1, 1, 'h20 | (200 << 9), 0, "R8");
    step(1, 1, 'h20 | (100 << 9), 0, "R8");
    step(1, 1, 'h20 | (101 << 9), 0, "R8");
    idle(8, "R8");
    // R9: clear alone, then clear with a same-cycle access
    step(0, 0, 0, 1, "R9");
    idle(8, "R9 cleared");
    step(1, 0, 'h3000, 1, "R9");
    idle(8, "R9 clear then count");
    // R10: saturation of access counters
    for (int k = 0; k < 70; k++) step(1, 0, 'h1000, 0, "R10");
    idle(8, "R10");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule